// File: doc/BRIEF.md
# Serial Audio Data Port Framer

This block moves audio samples between a codec core and an external serial device when the serial path is chosen instead of the parallel bus. Each frame carries a captured left/right sample pair out on `sdout` and brings a playback left/right pair in on `sdin`. The control path stays on the parallel bus. The external device supplies the bit clock `sclk` and the frame marker `fsync`. Both are oversampled by the block's own clock `clk` through a short synchronizer.

A 2-bit `fmt_sel` picks one of three frame layouts. Every sample is 16 bits, sent MSB first, and left always comes before right. A dense 32-bit layout packs the two samples back to back. A 64-bit wide layout gives each sample a 32-bit slot with zeros after the LSB. A 64-bit status layout follows the two samples with a 32-bit status word. That word is zeros followed by four flags: interrupt, capture enable, playback enable and overrange.

A frame begins on the bit clock after the one in which `fsync` is high. The layout, the capture samples and the status flags are all taken at that moment.

Top module: `sap_serial_port`

## Requirements
- R1: After reset `sdout` and `play_valid` are 0, and `sdout` stays 0 on every bit until a frame has been started by `fsync`.
- R2: The port samples `fsync` at each rising `sclk` edge. A high value makes the next rising edge drive bit 0 of a new frame. `sdout` changes only after rising `sclk` edges, and `sdin` is sampled at falling edges.
- R3: With `fmt_sel`=2'b10 the frame is 32 bits: bits 0..15 carry the left sample and bits 16..31 the right sample, each MSB first.
- R4: With `fmt_sel`=2'b01 the frame is 64 bits: left in bits 0..15, zeros in 16..31, right in 32..47 and zeros in 48..63.
- R5: With `fmt_sel`=2'b00 the frame is 64 bits: left in bits 0..15, right in 16..31 and zeros in 32..59. Bit 60 carries `irq_flag`, bit 61 `cap_en_flag`, bit 62 `play_en_flag` and bit 63 `ovr_flag`.
- R6: If `cap_ready` is low when a frame starts, both sample slots of that frame are sent as zeros. The status bits of layout 2'b00 are still sent.
- R7: `sdin` bits in the sample positions of the running layout form `play_left`/`play_right`, MSB first. `play_valid` pulses for exactly one `clk` cycle after the falling edge of the last right-sample bit. Bits in pad or status positions are ignored.
- R8: The layout, samples and flags are taken at frame start. Changes to `fmt_sel`, `cap_left`, `cap_right` or the flags during a frame do not alter that frame.
- R9: After the last bit of a frame, `sdout` is 0 on each further bit until the next `fsync`.
- R10: While `port_en` is low, `sdout` is 0, no frame starts and `play_valid` never pulses. An `fsync` while `fmt_sel`=2'b11 starts no frame.
- R11: An `fsync` during the last bit of a frame still lets that bit go out, and the next frame follows with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Serial port enable |
| fmt_sel | input | 2 | Frame layout select |
| sclk | input | 1 | External bit clock |
| fsync | input | 1 | External frame marker |
| sdin | input | 1 | Serial playback data in |
| sdout | output | 1 | Serial capture data out |
| cap_left | input | 16 | Captured left sample |
| cap_right | input | 16 | Captured right sample |
| cap_ready | input | 1 | Capture pair valid |
| irq_flag | input | 1 | Interrupt flag for status word |
| cap_en_flag | input | 1 | Capture-enable flag for status word |
| play_en_flag | input | 1 | Playback-enable flag for status word |
| ovr_flag | input | 1 | Overrange flag for status word |
| play_left | output | 16 | Received left sample |
| play_right | output | 16 | Received right sample |
| play_valid | output | 1 | One-cycle pulse when a received pair is complete |

## Verification
Each layout is driven with asymmetric sample values, such as a lone MSB or a lone LSB, so that a swapped channel, a reversed bit order or a shifted slot shows up as a distinct wrong vector. The `sdin` pad and status positions are filled with ones, so a receiver that samples outside the sample slots corrupts `play_left`/`play_right`. The `play_valid` count is taken at the bit just before the last right-sample bit and again right after it. Separate frames cover a missing capture pair, a layout change in mid-frame, back-to-back frames, and the disabled and reserved settings.

// File: rtl/sap_pkg.sv
package sap_pkg;
  localparam int SAMPLE_W  = 16;
  localparam int FRAME_MAX = 64;
  localparam int STAT_W    = 4;
  localparam int STAT_BASE = FRAME_MAX - STAT_W;
  localparam int IDX_W     = $clog2(FRAME_MAX + 1);
  localparam int POS_W     = $clog2(SAMPLE_W);

  typedef enum logic [1:0] {
    FMT_STAT   = 2'b00,
    FMT_WIDE   = 2'b01,
    FMT_PACKED = 2'b10,
    FMT_OFF    = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    SL_LEFT  = 2'd0,
    SL_RIGHT = 2'd1,
    SL_STAT  = 2'd2,
    SL_PAD   = 2'd3
  } slot_kind_e;

  typedef struct packed {
    slot_kind_e         kind;
    logic [POS_W-1:0]   pos;
  } slot_t;

  // Number of bits in one frame of the given layout.
  function automatic logic [IDX_W-1:0] frame_len(fmt_e f);
    case (f)
      FMT_PACKED: frame_len = IDX_W'(2 * SAMPLE_W);
      FMT_WIDE,
      FMT_STAT:   frame_len = IDX_W'(FRAME_MAX);
      default:    frame_len = '0;
    endcase
  endfunction

  // What the bit at index idx of a frame carries, and which bit of it.
  function automatic slot_t slot_of(fmt_e f, logic [IDX_W-1:0] idx);
    int i;
    slot_t s;
    i      = int'(idx);
    s.kind = SL_PAD;
    s.pos  = POS_W'(SAMPLE_W - 1 - (i % SAMPLE_W));
    case (f)
      FMT_PACKED, FMT_STAT: begin
        if (i < SAMPLE_W)          s.kind = SL_LEFT;
        else if (i < 2 * SAMPLE_W) s.kind = SL_RIGHT;
        else if (f == FMT_STAT && i >= STAT_BASE && i < FRAME_MAX) begin
          s.kind = SL_STAT;
          s.pos  = POS_W'(i - STAT_BASE);
        end
      end
      FMT_WIDE: begin
        if (i < SAMPLE_W)                              s.kind = SL_LEFT;
        else if (i >= 2 * SAMPLE_W && i < 3 * SAMPLE_W) s.kind = SL_RIGHT;
      end
      default: s.kind = SL_PAD;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sap_edge_sync.sv
module sap_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic fsync_i,
  input  logic sdin_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic fsync_s,
  output logic sdin_s
);
  localparam int LINES = 3;

  logic [LINES-1:0] stg [STAGES];
  logic             sclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      sclk_d <= 1'b0;
    end else begin
      stg[0] <= {sclk_i, fsync_i, sdin_i};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      sclk_d <= stg[STAGES-1][2];
    end
  end

  assign sclk_rise = stg[STAGES-1][2] & ~sclk_d;
  assign sclk_fall = ~stg[STAGES-1][2] & sclk_d;
  assign fsync_s   = stg[STAGES-1][1];
  assign sdin_s    = stg[STAGES-1][0];
endmodule

// File: rtl/sap_tx.sv
module sap_tx
  import sap_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rise,
  input  logic                fsync_s,
  input  logic                port_en,
  input  logic [1:0]          fmt_sel,
  input  logic [SAMPLE_W-1:0] cap_left,
  input  logic [SAMPLE_W-1:0] cap_right,
  input  logic                cap_ready,
  input  logic [STAT_W-1:0]   stat_flags,
  output logic                sdout_q,
  output logic                line_live,
  output logic [IDX_W-1:0]    line_idx,
  output fmt_e                line_fmt,
  output logic                frame_start
);
  logic [SAMPLE_W-1:0] sh_l, sh_r;
  logic [STAT_W-1:0]   sh_st;
  fmt_e                fmt_q;
  logic                live;
  logic [IDX_W-1:0]    cnt;
  logic                in_frame;
  logic                bit_now;
  slot_t               nxt;

  assign in_frame    = live && (cnt < frame_len(fmt_q)) && port_en;
  assign nxt         = slot_of(fmt_q, cnt);
  assign frame_start = rise && fsync_s && port_en && (fmt_e'(fmt_sel) != FMT_OFF);

  always_comb begin
    case (nxt.kind)
      SL_LEFT:  bit_now = sh_l[nxt.pos];
      SL_RIGHT: bit_now = sh_r[nxt.pos];
      SL_STAT:  bit_now = sh_st[nxt.pos[$clog2(STAT_W)-1:0]];
      default:  bit_now = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sdout_q   <= 1'b0;
      line_live <= 1'b0;
      line_idx  <= '0;
      line_fmt  <= FMT_OFF;
      fmt_q     <= FMT_OFF;
      live      <= 1'b0;
      cnt       <= '0;
      sh_l      <= '0;
      sh_r      <= '0;
      sh_st     <= '0;
    end else if (rise) begin
      sdout_q   <= in_frame ? bit_now : 1'b0;
      line_live <= in_frame;
      line_idx  <= cnt;
      line_fmt  <= fmt_q;
      if (in_frame) cnt <= cnt + 1'b1;
      if (frame_start) begin
        live  <= 1'b1;
        cnt   <= '0;
        fmt_q <= fmt_e'(fmt_sel);
        sh_l  <= cap_ready ? cap_left  : '0;
        sh_r  <= cap_ready ? cap_right : '0;
        sh_st <= stat_flags;
      end else if (!port_en) begin
        live <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sap_rx.sv
module sap_rx
  import sap_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fall,
  input  logic                sdin_s,
  input  logic                port_en,
  input  logic                line_live,
  input  slot_t               line_slot,
  output logic [SAMPLE_W-1:0] play_left,
  output logic [SAMPLE_W-1:0] play_right,
  output logic                play_valid,
  output logic                rx_last
);
  logic [SAMPLE_W-1:0] lsh, rsh;
  logic                take;

  assign take    = fall && line_live && port_en;
  assign rx_last = take && (line_slot.kind == SL_RIGHT) && (line_slot.pos == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lsh        <= '0;
      rsh        <= '0;
      play_left  <= '0;
      play_right <= '0;
      play_valid <= 1'b0;
    end else begin
      play_valid <= 1'b0;
      if (take && line_slot.kind == SL_LEFT)  lsh <= {lsh[SAMPLE_W-2:0], sdin_s};
      if (take && line_slot.kind == SL_RIGHT) rsh <= {rsh[SAMPLE_W-2:0], sdin_s};
      if (rx_last) begin
        play_left  <= lsh;
        play_right <= {rsh[SAMPLE_W-2:0], sdin_s};
        play_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sap_serial_port.sv
module sap_serial_port
  import sap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                port_en,
  input  logic [1:0]          fmt_sel,
  input  logic                sclk,
  input  logic                fsync,
  input  logic                sdin,
  output logic                sdout,
  input  logic [SAMPLE_W-1:0] cap_left,
  input  logic [SAMPLE_W-1:0] cap_right,
  input  logic                cap_ready,
  input  logic                irq_flag,
  input  logic                cap_en_flag,
  input  logic                play_en_flag,
  input  logic                ovr_flag,
  output logic [SAMPLE_W-1:0] play_left,
  output logic [SAMPLE_W-1:0] play_right,
  output logic                play_valid
);
  logic             tx_rise, rx_fall, fsync_s, sdin_s;
  logic             sdout_q, line_live, frame_start, rx_last;
  logic [IDX_W-1:0] line_idx;
  fmt_e             line_fmt;
  slot_t            line_slot;
  slot_kind_e       line_kind;
  logic [STAT_W-1:0] stat_flags;

  // Status bit 0 goes out first.
  assign stat_flags = {ovr_flag, play_en_flag, cap_en_flag, irq_flag};

  sap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .fsync_i(fsync), .sdin_i(sdin),
    .sclk_rise(tx_rise), .sclk_fall(rx_fall), .fsync_s(fsync_s), .sdin_s(sdin_s)
  );

  sap_tx u_tx (
    .clk(clk), .rst_n(rst_n), .rise(tx_rise), .fsync_s(fsync_s), .port_en(port_en),
    .fmt_sel(fmt_sel), .cap_left(cap_left), .cap_right(cap_right),
    .cap_ready(cap_ready), .stat_flags(stat_flags), .sdout_q(sdout_q),
    .line_live(line_live), .line_idx(line_idx), .line_fmt(line_fmt),
    .frame_start(frame_start)
  );

  assign line_slot = slot_of(line_fmt, line_idx);
  assign line_kind = line_slot.kind;

  sap_rx u_rx (
    .clk(clk), .rst_n(rst_n), .fall(rx_fall), .sdin_s(sdin_s), .port_en(port_en),
    .line_live(line_live), .line_slot(line_slot), .play_left(play_left),
    .play_right(play_right), .play_valid(play_valid), .rx_last(rx_last)
  );

  assign sdout = sdout_q & port_en;
endmodule

// File: rtl/sap_serial_port_chk.sv
module sap_serial_port_chk
  import sap_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       port_en,
  input logic       sdout_q,
  input logic       play_valid,
  input logic       tx_rise,
  input logic       rx_fall,
  input logic       line_live,
  input slot_kind_e line_kind,
  input logic       frame_start
);
  // R2
  stable_between_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_rise |=> $stable(sdout_q));

  // R4
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_live && line_kind == SL_PAD) |-> !sdout_q);

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_live |-> !sdout_q);

  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_valid |=> !play_valid);

  // R7
  pulse_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_fall |=> !play_valid);

  // R10
  disabled_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> !play_valid);

  // R10
  disabled_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> !frame_start);
endmodule

bind sap_serial_port sap_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .sdout_q(sdout_q),
  .play_valid(play_valid), .tx_rise(tx_rise), .rx_fall(rx_fall),
  .line_live(line_live), .line_kind(line_kind), .frame_start(frame_start)
);

// File: tb/sap_serial_port_bench.sv
`timescale 1ns/1ps
module sap_serial_port_bench;
  localparam int HALF = 8;

  logic clk = 0, rst_n = 0, port_en = 0, sclk = 0, fsync = 0, sdin = 0;
  logic [1:0] fmt_sel = 2'b10;
  logic [15:0] cap_left = 0, cap_right = 0;
  logic cap_ready = 0, irq_flag = 0, cap_en_flag = 0, play_en_flag = 0, ovr_flag = 0;
  logic sdout, play_valid;
  logic [15:0] play_left, play_right;

  int checks = 0, failures = 0, pv_cnt = 0;
  logic [15:0] pv_l, pv_r;

  always #2 clk = ~clk;

  sap_serial_port u_sap_serial_port (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .fmt_sel(fmt_sel), .sclk(sclk),
    .fsync(fsync), .sdin(sdin), .sdout(sdout), .cap_left(cap_left),
    .cap_right(cap_right), .cap_ready(cap_ready), .irq_flag(irq_flag),
    .cap_en_flag(cap_en_flag), .play_en_flag(play_en_flag), .ovr_flag(ovr_flag),
    .play_left(play_left), .play_right(play_right), .play_valid(play_valid)
  );

  always @(posedge clk) if (rst_n && play_valid) begin
    pv_cnt = pv_cnt + 1;
    pv_l   = play_left;
    pv_r   = play_right;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One bit period: rise with fs/din applied, then fall; sample sdout before the next rise.
  task automatic bit_period(input logic fs, input logic din, output logic dout);
    @(negedge clk);
    fsync = fs; sdin = din; sclk = 1;
    repeat (HALF) @(posedge clk);
    @(negedge clk); sclk = 0;
    repeat (HALF) @(posedge clk);
    @(negedge clk); dout = sdout;
  endtask

  task automatic set_cap(input logic [1:0] f, input logic [15:0] l, input logic [15:0] r,
                         input logic rdy, input logic [3:0] st);
    fmt_sel = f; cap_left = l; cap_right = r; cap_ready = rdy;
    {irq_flag, cap_en_flag, play_en_flag, ovr_flag} = st;
  endtask

  task automatic fsync_bit();
    logic d;
    bit_period(1'b1, 1'b0, d);
  endtask

  // Runs one frame already started; compares the sent vector and the received pair.
  task automatic run_frame(input logic [1:0] f, input logic [15:0] l, input logic [15:0] r,
                           input logic rdy, input logic [3:0] st,
                           input logic [15:0] rl, input logic [15:0] rr,
                           input bit chain, input bit want_pv, input string req);
    logic [63:0] txv, rxv, got;
    logic [15:0] el, er;
    int n, last_r, base;
    logic d;
    el = rdy ? l : 16'h0;
    er = rdy ? r : 16'h0;
    case (f)
      2'b10: begin n = 32; txv = {el, er, 32'h0};            rxv = {rl, rr, 32'hFFFF_FFFF};      last_r = 31; end
      2'b01: begin n = 64; txv = {el, 16'h0, er, 16'h0};     rxv = {rl, 16'hFFFF, rr, 16'hFFFF}; last_r = 47; end
      default: begin n = 64; txv = {el, er, 28'h0, st};      rxv = {rl, rr, 32'hFFFF_FFFF};      last_r = 31; end
    endcase
    got  = '0;
    base = pv_cnt;
    for (int i = 0; i < n; i++) begin
      bit_period(chain && (i == n - 1), rxv[63-i], d);
      got[63-i] = d;
      if (want_pv && i == last_r - 1)
        chk(pv_cnt == base, "R7", "no pulse before last right bit", 64'(pv_cnt - base), 64'd0);
    end
    chk(got == txv, req, "frame bits", got, txv);
    if (want_pv) begin
      chk(pv_cnt == base + 1, "R7", "one play pulse", 64'(pv_cnt - base), 64'd1);
      chk(pv_l == rl && pv_r == rr, "R7", "received pair", {32'h0, pv_l, pv_r}, {32'h0, rl, rr});
    end else
      chk(pv_cnt == base, req, "no play pulse", 64'(pv_cnt - base), 64'd0);
  endtask

  task automatic idle_bits(input int n, input string req);
    logic [63:0] got;
    logic d;
    got = '0;
    for (int i = 0; i < n; i++) begin
      bit_period(1'b0, 1'b1, d);
      got[i] = d;
    end
    chk(got == 64'h0, req, "idle sdout", got, 64'h0);
  endtask

  task automatic t_reset();
    chk(sdout == 1'b0 && play_valid == 1'b0, "R1", "reset outputs", {62'h0, sdout, play_valid}, 64'h0);
    set_cap(2'b10, 16'hFFFF, 16'hFFFF, 1'b1, 4'hF);
    idle_bits(6, "R1");
  endtask

  task automatic t_packed();
    set_cap(2'b10, 16'h8001, 16'h1E0F, 1'b1, 4'h0);
    fsync_bit();
    run_frame(2'b10, 16'h8001, 16'h1E0F, 1'b1, 4'h0, 16'h8000, 16'h0001, 1'b0, 1'b1, "R3");
    idle_bits(5, "R9");
  endtask

  task automatic t_wide();
    set_cap(2'b01, 16'hA5C3, 16'h0001, 1'b1, 4'hF);
    fsync_bit();
    run_frame(2'b01, 16'hA5C3, 16'h0001, 1'b1, 4'hF, 16'h1234, 16'hFEDC, 1'b0, 1'b1, "R4");
  endtask

  task automatic t_status();
    set_cap(2'b00, 16'h7FFE, 16'hC003, 1'b1, 4'b1010);
    fsync_bit();
    run_frame(2'b00, 16'h7FFE, 16'hC003, 1'b1, 4'b1010, 16'h0F0F, 16'hF0F0, 1'b0, 1'b1, "R5");
    set_cap(2'b00, 16'h0002, 16'h4000, 1'b1, 4'b0101);
    fsync_bit();
    run_frame(2'b00, 16'h0002, 16'h4000, 1'b1, 4'b0101, 16'h0001, 16'h8000, 1'b0, 1'b1, "R5");
  endtask

  task automatic t_not_ready();
    set_cap(2'b00, 16'hBEEF, 16'hCAFE, 1'b0, 4'b0011);
    fsync_bit();
    run_frame(2'b00, 16'hBEEF, 16'hCAFE, 1'b0, 4'b0011, 16'h5555, 16'hAAAA, 1'b0, 1'b1, "R6");
  endtask

  task automatic t_latch();
    set_cap(2'b10, 16'h1357, 16'h2468, 1'b1, 4'h0);
    fsync_bit();
    set_cap(2'b01, 16'hFFFF, 16'h0000, 1'b0, 4'hF);
    run_frame(2'b10, 16'h1357, 16'h2468, 1'b1, 4'h0, 16'h4321, 16'h8765, 1'b0, 1'b1, "R8");
    idle_bits(4, "R8");
  endtask

  task automatic t_chain();
    set_cap(2'b10, 16'h8421, 16'h1248, 1'b1, 4'h0);
    fsync_bit();
    set_cap(2'b00, 16'h00FF, 16'hFF00, 1'b1, 4'b1001);
    run_frame(2'b10, 16'h8421, 16'h1248, 1'b1, 4'h0, 16'h0003, 16'hC000, 1'b1, 1'b1, "R11");
    run_frame(2'b00, 16'h00FF, 16'hFF00, 1'b1, 4'b1001, 16'h7777, 16'h1111, 1'b0, 1'b1, "R11");
  endtask

  task automatic t_disabled();
    port_en = 0;
    set_cap(2'b10, 16'hFFFF, 16'hFFFF, 1'b1, 4'hF);
    fsync_bit();
    run_frame(2'b10, 16'h0000, 16'h0000, 1'b0, 4'h0, 16'h1111, 16'h2222, 1'b0, 1'b0, "R10");
    port_en = 1;
    set_cap(2'b11, 16'hFFFF, 16'hFFFF, 1'b1, 4'hF);
    fsync_bit();
    run_frame(2'b10, 16'h0000, 16'h0000, 1'b0, 4'h0, 16'h1111, 16'h2222, 1'b0, 1'b0, "R10");
  endtask

  initial begin
    #(4ns * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1; port_en = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_packed();
    t_wide();
    t_status();
    t_not_ready();
    t_latch();
    t_chain();
    t_disabled();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule